// File: doc/BRIEF.md
# Weight-Reuse Difference Checking Engine

This block feeds a binary convolution in which weight kernels run one after another in an order chosen offline so that neighbouring kernels look alike. The first kernel of a group arrives with its real bits. Every later kernel arrives as a change mask against the kernel before it: a 0 bit means the weight at that position is the same, and a 1 bit means it is different. The engine keeps a base register that holds the real kernel currently in use. It rebuilds each new kernel by XOR of the base with the mask, and broadcasts the changed positions together with the rebuilt weight bits to the processing elements. Each processing element holds different rows of the input activation. No subtraction is needed on chip.

A mask with no bit set means the whole previous result can be reused. In that case nothing is broadcast, and a one-cycle reuse pulse is raised. Because kernels execute in a permuted order inside a window of WIN slots, the engine writes the original kernel index of each execution slot into a sequence table. Output-map results are written back through a lookup port of that table, which restores their natural order.

The controller has two states. S_ACCEPT holds in_ready high. Its transitions are: an accepted first kernel goes to S_BCAST; an accepted non-zero mask goes to S_BCAST; an accepted zero mask stays in S_ACCEPT and raises the reuse pulse. S_BCAST holds bc_valid high, and returns to S_ACCEPT on the cycle bc_ready is seen.

Top module: `wr_diff_engine`

## Requirements
- R1: After reset, bc_valid and reuse_pulse are 0, in_ready is 1, every sequence-table entry reads 0 and the base register is 0.
- R2: When a kernel with in_first=1 is accepted (in_valid and in_ready high at a clock edge), the next cycle shows bc_valid=1, bc_first=1, bc_mask all ones, bc_weights equal to the raw in_bits, and bc_slot=0. The base register is loaded with those bits.
- R3: When a non-first kernel with a non-zero mask is accepted, the next cycle shows bc_valid=1, bc_first=0, bc_mask equal to the mask, and bc_weights equal to the previous base XOR the mask. The base register takes that new value.
- R4: When a non-first kernel with an all-zero mask is accepted, no broadcast follows. reuse_pulse is 1 for exactly the next cycle, the base is unchanged and in_ready stays 1.
- R5: While bc_valid is 1, in_ready is 0. An input offered in that time is neither taken nor recorded. While bc_ready is 0, all broadcast fields hold steady. The broadcast completes at the first edge where bc_ready is 1.
- R6: Execution slots count accepted kernels. A first kernel takes slot 0, and each later kernel takes the previous slot plus one, wrapping from WIN-1 to 0. bc_slot shows the slot of the broadcast kernel.
- R7: On each accepted kernel, in_index is written to the sequence-table entry of its slot. From the next cycle, rev_index shows the stored index of the entry selected by rev_slot (combinational read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Kernel word offered |
| in_ready | output | 1 | Engine can take a kernel word |
| in_first | input | 1 | Word is a raw first kernel, not a mask |
| in_bits | input | KW | Raw kernel bits or change mask |
| in_index | input | IW | Original kernel index of this word |
| bc_valid | output | 1 | Broadcast offered to processing elements |
| bc_ready | input | 1 | Processing elements take the broadcast |
| bc_first | output | 1 | Broadcast is a full first kernel |
| bc_mask | output | KW | Changed positions |
| bc_weights | output | KW | Real weight bits of the new kernel |
| bc_slot | output | IW | Execution slot of the broadcast kernel |
| reuse_pulse | output | 1 | Previous result fully reused |
| rev_slot | input | IW | Slot to look up for reverting |
| rev_index | output | IW | Original index stored for rev_slot |

## Verification
A broadcast or a reuse pulse is due in the cycle after the edge that accepts the kernel, and a broadcast then lasts until the edge where bc_ready is high. A sequence-table entry can be read in the cycle after its kernel is accepted. The bench drives inputs at the falling edge and compares every output at each falling edge with a behavioural model. That model applies the stimulus of one cycle at the next rising edge, so every expectation is placed exactly one register stage after its cause. Long stalls, a wrap of the slot counter and a restart with a new first kernel show the hold and counting rules at their boundaries.

// File: rtl/wr_diff_pkg.sv
package wr_diff_pkg;
    typedef enum logic {
        S_ACCEPT = 1'b0,
        S_BCAST  = 1'b1
    } wr_state_t;
endpackage

// File: rtl/wr_seq_table.sv
module wr_seq_table #(
    parameter int DEPTH = 64,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_slot,
    input  logic [IW-1:0] wr_index,
    input  logic [IW-1:0] rd_slot,
    output logic [IW-1:0] rd_index
);
    logic [IW-1:0] entry_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q[g] <= '0;
            end else if (wr_en && (wr_slot == IW'(g))) begin
                entry_q[g] <= wr_index;
            end
        end
    end

    assign rd_index = entry_q[rd_slot];
endmodule

// File: rtl/wr_base_reg.sv
module wr_base_reg #(
    parameter int KW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_raw,
    input  logic          apply_mask,
    input  logic [KW-1:0] din,
    output logic [KW-1:0] base_q,
    output logic [KW-1:0] rebuilt
);
    assign rebuilt = base_q ^ din;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (load_raw) begin
            base_q <= din;
        end else if (apply_mask) begin
            base_q <= rebuilt;
        end
    end
endmodule

// File: rtl/wr_diff_engine.sv
module wr_diff_engine
    import wr_diff_pkg::*;
#(
    parameter int KW  = 16,
    parameter int WIN = 64,
    parameter int IW  = $clog2(WIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_first,
    input  logic [KW-1:0] in_bits,
    input  logic [IW-1:0] in_index,
    output logic          bc_valid,
    input  logic          bc_ready,
    output logic          bc_first,
    output logic [KW-1:0] bc_mask,
    output logic [KW-1:0] bc_weights,
    output logic [IW-1:0] bc_slot,
    output logic          reuse_pulse,
    input  logic [IW-1:0] rev_slot,
    output logic [IW-1:0] rev_index
);
    localparam logic [IW-1:0] LAST_SLOT = IW'(WIN - 1);

    wr_state_t     state_q, state_d;
    logic          take;
    logic          mask_zero;
    logic [IW-1:0] slot_ctr_q;
    logic [IW-1:0] cur_slot;
    logic [KW-1:0] base_q;
    logic [KW-1:0] rebuilt;

    assign in_ready  = (state_q == S_ACCEPT);
    assign take      = in_valid && in_ready;
    assign mask_zero = (in_bits == '0);
    assign cur_slot  = in_first ? '0 : slot_ctr_q;

    wr_base_reg #(.KW(KW)) u_base (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_raw   (take && in_first),
        .apply_mask (take && !in_first),
        .din        (in_bits),
        .base_q     (base_q),
        .rebuilt    (rebuilt)
    );

    wr_seq_table #(.DEPTH(WIN), .IW(IW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (take),
        .wr_slot  (cur_slot),
        .wr_index (in_index),
        .rd_slot  (rev_slot),
        .rd_index (rev_index)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_ACCEPT;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_ACCEPT: begin
                if (take && (in_first || !mask_zero)) begin
                    state_d = S_BCAST;
                end
            end
            S_BCAST: begin
                if (bc_ready) begin
                    state_d = S_ACCEPT;
                end
            end
            default: state_d = S_ACCEPT;
        endcase
    end

    // slot counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_ctr_q <= '0;
        end else if (take) begin
            slot_ctr_q <= (cur_slot == LAST_SLOT) ? '0 : cur_slot + 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bc_valid    <= 1'b0;
            bc_first    <= 1'b0;
            bc_mask     <= '0;
            bc_weights  <= '0;
            bc_slot     <= '0;
            reuse_pulse <= 1'b0;
        end else begin
            reuse_pulse <= 1'b0;
            unique case (state_q)
                S_ACCEPT: begin
                    if (take) begin
                        if (in_first) begin
                            bc_valid   <= 1'b1;
                            bc_first   <= 1'b1;
                            bc_mask    <= '1;
                            bc_weights <= in_bits;
                            bc_slot    <= cur_slot;
                        end else if (mask_zero) begin
                            reuse_pulse <= 1'b1;
                        end else begin
                            bc_valid   <= 1'b1;
                            bc_first   <= 1'b0;
                            bc_mask    <= in_bits;
                            bc_weights <= rebuilt;
                            bc_slot    <= cur_slot;
                        end
                    end
                end
                S_BCAST: begin
                    if (bc_ready) begin
                        bc_valid <= 1'b0;
                    end
                end
                default: bc_valid <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/wr_diff_engine_chk.sv
module wr_diff_engine_chk #(
    parameter int KW  = 16,
    parameter int WIN = 64,
    parameter int IW  = $clog2(WIN)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          in_first,
    input logic [KW-1:0] in_bits,
    input logic          bc_valid,
    input logic          bc_ready,
    input logic          bc_first,
    input logic [KW-1:0] bc_mask,
    input logic [KW-1:0] bc_weights,
    input logic [IW-1:0] bc_slot,
    input logic          reuse_pulse,
    input logic [KW-1:0] base_q
);
    // R2
    first_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_first) |=>
        (bc_valid && bc_first && bc_mask == '1 && bc_weights == $past(in_bits) && bc_slot == '0));

    // R3
    rebuild_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_first && in_bits != '0) |=>
        (bc_valid && !bc_first && bc_mask == $past(in_bits)
         && bc_weights == ($past(base_q) ^ $past(in_bits))));

    // R4
    reuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_first && in_bits == '0) |=>
        (reuse_pulse && !bc_valid && in_ready && $stable(base_q)));

    // R4
    reuse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reuse_pulse |-> !bc_valid);

    // R5
    bc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_valid && !bc_ready) |=>
        (bc_valid && $stable(bc_mask) && $stable(bc_weights) && $stable(bc_first) && $stable(bc_slot)));

    // R5
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bc_valid |-> !in_ready);
endmodule

bind wr_diff_engine wr_diff_engine_chk #(.KW(KW), .WIN(WIN), .IW(IW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_first    (in_first),
    .in_bits     (in_bits),
    .bc_valid    (bc_valid),
    .bc_ready    (bc_ready),
    .bc_first    (bc_first),
    .bc_mask     (bc_mask),
    .bc_weights  (bc_weights),
    .bc_slot     (bc_slot),
    .reuse_pulse (reuse_pulse),
    .base_q      (base_q)
);

// File: tb/tb_wr_diff_engine.sv
`timescale 1ns/1ps
module tb_wr_diff_engine;
    localparam int KW  = 16;
    localparam int WIN = 64;
    localparam int IW  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          in_first = 1'b0;
    logic [KW-1:0] in_bits = '0;
    logic [IW-1:0] in_index = '0;
    logic          bc_valid;
    logic          bc_ready = 1'b0;
    logic          bc_first;
    logic [KW-1:0] bc_mask;
    logic [KW-1:0] bc_weights;
    logic [IW-1:0] bc_slot;
    logic          reuse_pulse;
    logic [IW-1:0] rev_slot = '0;
    logic [IW-1:0] rev_index;

    always #5 clk = ~clk;

    wr_diff_engine #(.KW(KW), .WIN(WIN), .IW(IW)) dut (.*);

    // behavioural model
    bit          m_bcv, m_first, m_reuse;
    logic [KW-1:0] m_base, m_mask, m_w;
    int          m_slot, m_ctr;
    int          m_tbl [WIN];
    int          m_rslot;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_bcv = 0; m_first = 0; m_reuse = 0;
        m_base = '0; m_mask = '0; m_w = '0;
        m_slot = 0; m_ctr = 0; m_rslot = 0;
        for (int i = 0; i < WIN; i++) m_tbl[i] = 0;
    endtask

    // compare outputs, then drive one cycle of stimulus and predict the next edge
    task automatic step(bit iv, bit ifirst, logic [KW-1:0] ibits, int iidx, bit bready, int rslot);
        @(negedge clk);
        chk("R5 in_ready", 32'(in_ready), 32'(!m_bcv));
        chk("R5 bc_valid", 32'(bc_valid), 32'(m_bcv));
        chk("R4 reuse_pulse", 32'(reuse_pulse), 32'(m_reuse));
        if (m_bcv) begin
            chk(m_first ? "R2 bc_first" : "R3 bc_first", 32'(bc_first), 32'(m_first));
            chk(m_first ? "R2 bc_mask" : "R3 bc_mask", 32'(bc_mask), 32'(m_mask));
            chk(m_first ? "R2 bc_weights" : "R3 bc_weights", 32'(bc_weights), 32'(m_w));
            chk("R6 bc_slot", 32'(bc_slot), 32'(m_slot));
        end
        chk("R7 rev_index", 32'(rev_index), 32'(m_tbl[m_rslot]));
        in_valid = iv; in_first = ifirst; in_bits = ibits;
        in_index = IW'(iidx); bc_ready = bready; rev_slot = IW'(rslot);
        m_rslot = rslot;
        m_reuse = 0;
        if (m_bcv) begin
            if (bready) m_bcv = 0;
        end else if (iv) begin
            int s;
            s = ifirst ? 0 : m_ctr;
            m_tbl[s] = iidx;
            m_ctr = (s + 1) % WIN;
            if (ifirst) begin
                m_base = ibits;
                m_bcv = 1; m_first = 1; m_mask = '1; m_w = ibits; m_slot = s;
            end else if (ibits == '0) begin
                m_reuse = 1;
            end else begin
                m_base = m_base ^ ibits;
                m_bcv = 1; m_first = 0; m_mask = ibits; m_w = m_base; m_slot = s;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, table reads 0
        step(0, 0, '0, 0, 0, 5);
        step(0, 0, '0, 0, 0, 0);
        // R2 first kernel, held with bc_ready low (R5)
        step(1, 1, 16'hA5C3, 17, 0, 0);
        step(1, 0, 16'h00FF, 9, 0, 0);   // offered while busy: ignored (R5)
        step(1, 0, 16'h00FF, 9, 0, 0);
        step(0, 0, '0, 0, 1, 0);
        // R7 table slot 0 holds 17; R3 chain of masks
        step(1, 0, 16'h0101, 40, 1, 0);
        step(0, 0, '0, 0, 1, 1);
        step(1, 0, 16'hF000, 3, 0, 1);
        step(0, 0, '0, 0, 0, 2);
        step(0, 0, '0, 0, 1, 2);
        // R4 zero masks back to back, then nonzero to see base kept
        step(1, 0, 16'h0000, 11, 1, 3);
        step(1, 0, 16'h0000, 12, 1, 3);
        step(1, 0, 16'h8001, 13, 1, 4);
        step(0, 0, '0, 0, 1, 5);
        // R6 wrap: zero masks to fill the window past WIN-1
        for (int k = 0; k < WIN - 2; k++) begin
            step(1, 0, 16'h0000, (k * 7) % WIN, 1, k % WIN);
        end
        step(1, 0, 16'h0010, 63, 1, 62);  // lands at slot 4 after wrap
        step(0, 0, '0, 0, 1, 63);
        step(0, 0, '0, 0, 1, 0);
        // R6 restart: new first kernel takes slot 0
        step(1, 1, 16'h1234, 50, 1, 4);
        step(0, 0, '0, 0, 1, 0);
        step(1, 0, 16'hFFFF, 51, 1, 1);
        step(0, 0, '0, 0, 1, 1);
        step(0, 0, '0, 0, 1, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule